// File: doc/BRIEF.md
# Prioritised Interrupt Collector

This block gathers up to 32 interrupt source lines into one interrupt request for a processor. A configurable subset of the sources (numbers 1 to `NUM_CTRL`) has a 16-bit control word. The word enables the source, holds its request flag, picks which edge or level of the input counts as a request, and gives it one of eight priority levels. Every source line passes through a two-flop synchroniser before it is examined.

Among the sources that are enabled, requesting and not masked, an arbiter picks the one with the highest level. A tie goes to the lower source number. The number of the winner appears in a status word, next to a 4-bit vector-base field that software sets. A registered interrupt output tells the processor that some source is winning. Two read-only words give the request flag of every source, whether or not the source is enabled.

Software reaches all state through a simple 16-bit register bus with halfword addresses. Reads are combinational and writes take effect at the clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every control word, the status word and the raw request words read 0, and `irq_o` is low.
- R2: The control word of source n (1..NUM_CTRL) sits at byte offset 0x100 + 2*(n-1). The enable is bit 12, the request flag bit 8, the sense mode bits 5:4 and the priority level bits 2:0. All other bits read 0.
- R3: In sense mode 00 a falling edge sets the request flag, and in mode 10 a rising edge sets it. The flag stays set until a write puts 0 in bit 8. Writing 1 to bit 8 neither sets nor clears it.
- R4: In sense mode 01 the request flag is the inverted input, and in mode 11 it is the input itself. Writes to bit 8 have no effect in these modes.
- R5: A source is eligible when it is enabled, requesting and has a nonzero level. The eligible source with the highest level wins, and on equal levels the lower source number wins.
- R6: A source with level 0 never wins, even when it is enabled and requesting.
- R7: The status word at offset 0x02 shows the winner number in bits 10:6, and 0 there when nothing wins. Bits 15:12 hold a vector base that a write to 0x02 sets and a read returns unchanged. Its other bits read 0.
- R8: `irq_o` is high in the cycle after a cycle with a winner, and low in the cycle after a cycle without one.
- R9: Offset 0x04 gives the request flags of sources 0..15 and offset 0x06 those of sources 16..31, one bit per source, whatever the enable. Sources without a control word read 0.
- R10: A disabled source in an edge mode still latches edges. Once it is enabled it competes with the flag it latched.
- R11: A change on an input shows in a level-mode request flag after exactly two rising clock edges, not after one.
- R12: A write to any offset that is not mapped changes nothing, and a read from it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset, halfword aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| src_i | input | NUM_SRC | Raw interrupt source lines |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Directed sequences cover each sense mode in turn. A rising edge is held and then removed, which shows that an edge flag is sticky and a level flag is not. Writes of 1 and then 0 to the request bit separate the edge flag's clear path from its ignore path. Two sources on equal and then unequal levels test the tie-break against the level comparison. Random phases then set all seventeen control words and the vector base to fresh values and flip random inputs. After each phase the winner, the interrupt line and both raw words are compared with a bench model, so that edge polarity, level polarity and masking are told apart over many combinations.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int DATA_W     = 16;
  localparam int LVL_W      = 3;
  localparam int EN_BIT     = 12;
  localparam int REQ_BIT    = 8;
  localparam int MODE_LSB   = 4;
  localparam int STS_VB_LSB = 12;
  localparam int STS_VB_W   = 4;
  localparam int STS_NUM_LSB = 6;

  typedef struct packed {
    logic             en;
    logic [1:0]       mode;   // bit1: active polarity, bit0: level sensitive
    logic [LVL_W-1:0] lvl;
  } src_cfg_t;

  function automatic src_cfg_t unpack_ctrl(input logic [DATA_W-1:0] w);
    src_cfg_t c;
    c.en   = w[EN_BIT];
    c.mode = w[MODE_LSB +: 2];
    c.lvl  = w[LVL_W-1:0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input src_cfg_t c, input logic req);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT]         = c.en;
    w[REQ_BIT]        = req;
    w[MODE_LSB +: 2]  = c.mode;
    w[LVL_W-1:0]      = c.lvl;
    return w;
  endfunction
endpackage

// File: rtl/icu_src_cell.sv
module icu_src_cell
  import icu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output src_cfg_t          cfg_o,
  output logic              pend_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic     prev_q;
  logic     flag_q, flag_d;
  src_cfg_t cfg_q, cfg_d;
  logic     sampled, pol, edge_mode, hit;

  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-2:0], raw_i};
    sampled   = sync_q[SYNC_STAGES-1];
    pol       = cfg_q.mode[1];
    edge_mode = ~cfg_q.mode[0];
    hit       = (sampled == pol) && (prev_q != pol);
    cfg_d     = unpack_ctrl(wdata_i);
    if (!edge_mode)                      flag_d = 1'b0;
    else if (hit)                        flag_d = 1'b1;
    else if (wr_i && !wdata_i[REQ_BIT])  flag_d = 1'b0;
    else                                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sampled;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (wr_i) cfg_q <= cfg_d;
  end

  assign cfg_o  = cfg_q;
  assign pend_o = edge_mode ? flag_q : (sampled == pol);

  // R3: a latched edge request survives any cycle without a write
  assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && flag_q && !wr_i) |=> pend_o);
  // R10: a qualifying edge sets the request whatever the enable
  assert_edge_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !wr_i && sync_q[SYNC_STAGES-1] == cfg_q.mode[1]
     && prev_q != cfg_q.mode[1]) |=> pend_o);
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
  import icu_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       elig_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  output logic                     win_valid_o,
  output logic [SRC_W-1:0]         win_idx_o
);
  logic [LVL_W-1:0] best;

  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best        = '0;
    // scan downward so that on equal levels the lower number is taken last
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!win_valid_o || lvl_i[i*LVL_W +: LVL_W] >= best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = SRC_W'(i);
        best        = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import icu_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int NUM_CTRL    = 17,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_BASE   = 'h100,
  parameter int STS_OFF     = 'h02,
  parameter int RAW_LO_OFF  = 'h04,
  parameter int RAW_HI_OFF  = 'h06
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  src_cfg_t                 cfg   [NUM_SRC];
  logic [NUM_SRC-1:0]       pend, elig;
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic                     win_valid;
  logic [SRC_W-1:0]         win_idx;
  logic [STS_VB_W-1:0]      vb_q;
  logic                     sts_wr, irq_d;

  genvar n;
  generate
    for (n = 0; n < NUM_SRC; n++) begin : g_src
      if (n >= 1 && n <= NUM_CTRL) begin : g_cell
        logic cell_wr;
        assign cell_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(CTRL_BASE + 2*(n-1)));
        icu_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
          .clk    (clk),
          .rst_n  (rst_n_int),
          .raw_i  (src_i[n]),
          .wr_i   (cell_wr),
          .wdata_i(bus_wdata),
          .cfg_o  (cfg[n]),
          .pend_o (pend[n])
        );
      end else begin : g_none
        assign cfg[n]  = '0;
        assign pend[n] = 1'b0;
      end
      assign elig[n] = cfg[n].en && pend[n] && (cfg[n].lvl != '0);
      assign lvl_flat[n*LVL_W +: LVL_W] = cfg[n].lvl;
    end
  endgenerate

  icu_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .elig_i     (elig),
    .lvl_i      (lvl_flat),
    .win_valid_o(win_valid),
    .win_idx_o  (win_idx)
  );

  assign sts_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(STS_OFF));
  assign irq_d  = win_valid;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  vb_q <= '0;
    else if (sts_wr) vb_q <= bus_wdata[STS_VB_LSB +: STS_VB_W];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) irq_o <= 1'b0;
    else            irq_o <= irq_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(STS_OFF)) begin
      bus_rdata[STS_VB_LSB +: STS_VB_W] = vb_q;
      bus_rdata[STS_NUM_LSB +: SRC_W]   = win_valid ? win_idx : '0;
    end else if (bus_addr == ADDR_W'(RAW_LO_OFF)) begin
      for (int i = 0; i < DATA_W && i < NUM_SRC; i++) bus_rdata[i] = pend[i];
    end else if (bus_addr == ADDR_W'(RAW_HI_OFF)) begin
      for (int i = DATA_W; i < 2*DATA_W && i < NUM_SRC; i++) bus_rdata[i-DATA_W] = pend[i];
    end else begin
      for (int i = 1; i <= NUM_CTRL; i++)
        if (bus_addr == ADDR_W'(CTRL_BASE + 2*(i-1))) bus_rdata = pack_ctrl(cfg[i], pend[i]);
    end
  end

  // R5: the chosen source is eligible
  assert_win_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    win_valid |-> (elig[win_idx] && cfg[win_idx].en && pend[win_idx]));
  // R6: a masked level can never be the winner
  assert_no_masked_win_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    win_valid |-> (cfg[win_idx].lvl != '0));
  // R8: the processor line follows arbitration one cycle later
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (|elig) |=> irq_o);
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(|elig) |=> !irq_o);
  // R7: the vector base moves only on a status write
  assert_vb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !sts_wr |=> $stable(vb_q));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam int NCTRL = 17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [9:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [NSRC-1:0] src_i;
  logic        irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench model of the configuration
  bit       m_en   [NSRC];
  bit [1:0] m_mode [NSRC];
  bit [2:0] m_lvl  [NSRC];
  bit       m_pend [NSRC];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_o(irq_o)
  );

  function automatic logic [9:0] ctrl_addr(input int n);
    return 10'(16'h100 + 2*(n-1));
  endfunction

  function automatic logic [15:0] ctrl_word(input bit en, input bit req, input bit [1:0] mode, input bit [2:0] lvl);
    return {3'b0, en, 3'b0, req, 2'b0, mode, 1'b0, lvl};
  endfunction

  function automatic int exp_winner();
    int w = 0;
    int best = 0;
    for (int i = 1; i <= NCTRL; i++)
      if (m_en[i] && m_pend[i] && m_lvl[i] != 0 && int'(m_lvl[i]) > best) begin
        best = int'(m_lvl[i]);
        w = i;
      end
    return w;
  endfunction

  function automatic logic [15:0] exp_raw(input int base);
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++) r[i] = m_pend[base+i];
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cfg_src(input int n, input bit en, input bit req, input bit [1:0] mode, input bit [2:0] lvl);
    wr(ctrl_addr(n), ctrl_word(en, req, mode, lvl));
    m_en[n] = en; m_mode[n] = mode; m_lvl[n] = lvl;
  endtask

  task automatic idle(input int c);
    repeat (c) @(posedge clk);
  endtask

  task automatic check_status(input string req, input bit [3:0] vb);
    logic [15:0] d;
    int w;
    w = exp_winner();
    rd(10'h002, d);
    check(req, d, {vb, 1'b0, 5'(w), 6'b0});
    check({req, " irq"}, {15'b0, irq_o}, {15'b0, w != 0});
  endtask

  initial begin
    logic [15:0] d;
    logic [NSRC-1:0] old_in;
    bit [3:0] vb;
    void'($urandom(32'h1C0_5EED));
    for (int i = 0; i < NSRC; i++) begin m_en[i] = 0; m_mode[i] = 0; m_lvl[i] = 0; m_pend[i] = 0; end
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; src_i = '0;
    vb = 4'h0;
    rst_n = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(3);

    // R1: reset state
    rd(10'h002, d); check("R1 status", d, 16'h0000);
    check("R1 irq", {15'b0, irq_o}, 16'h0);
    rd(ctrl_addr(1), d); check("R1 ctrl1", d, 16'h0000);
    rd(10'h004, d); check("R1 raw lo", d, 16'h0000);

    // R2/R4: field layout, request write ignored in level mode
    wr(ctrl_addr(3), 16'hFFFF);
    m_en[3] = 1; m_mode[3] = 2'b11; m_lvl[3] = 3'd7;
    rd(ctrl_addr(3), d); check("R2 ctrl layout", d, 16'h1037);

    // R11: two-flop synchroniser latency on a level source
    @(negedge clk) src_i[3] = 1'b1;
    @(posedge clk);
    @(negedge clk) bus_addr = 10'h004;
    #1 check("R11 one edge", {15'b0, bus_rdata[3]}, 16'h0);
    @(posedge clk);
    @(negedge clk) #1 check("R11 two edges", {15'b0, bus_rdata[3]}, 16'h1);
    m_pend[3] = 1;
    idle(2);
    check_status("R5 single", vb);

    // R4: low level mode follows inverted input
    cfg_src(3, 1, 1, 2'b01, 3'd7); m_pend[3] = 0;
    idle(3);
    rd(ctrl_addr(3), d); check("R4 low level", d, 16'h1017);

    // R6: level 0 masks an enabled requesting source; R9 still shows it
    cfg_src(3, 1, 0, 2'b11, 3'd0); m_pend[3] = 1;
    idle(3);
    check_status("R6 masked", vb);
    rd(10'h004, d); check("R9 raw masked", d, 16'h0008);

    // R3: rising edge sticks, write 1 keeps, write 0 clears
    cfg_src(5, 1, 0, 2'b10, 3'd4);
    @(negedge clk) src_i[5] = 1'b1;
    idle(5); m_pend[5] = 1;
    check_status("R3 rise set", vb);
    @(negedge clk) src_i[5] = 1'b0;
    idle(5);
    check_status("R3 sticky", vb);
    cfg_src(5, 1, 1, 2'b10, 3'd4);
    idle(2);
    check_status("R3 write one", vb);
    cfg_src(5, 1, 0, 2'b10, 3'd4); m_pend[5] = 0;
    idle(2);
    check_status("R3 write zero", vb);

    // R10: disabled source latches, then competes
    cfg_src(6, 0, 0, 2'b10, 3'd2);
    @(negedge clk) src_i[6] = 1'b1;
    idle(5); m_pend[6] = 1;
    check_status("R10 disabled", vb);
    rd(10'h004, d); check("R10 raw", d, 16'h0048);
    cfg_src(6, 1, 1, 2'b10, 3'd2);
    idle(2);
    check_status("R10 enabled", vb);

    // R5: tie to lower number, then higher level wins
    cfg_src(7, 1, 0, 2'b11, 3'd2);
    @(negedge clk) src_i[7] = 1'b1;
    idle(5); m_pend[7] = 1;
    check_status("R5 tie", vb);
    cfg_src(7, 1, 0, 2'b11, 3'd5);
    idle(2);
    check_status("R5 level", vb);

    // R7: vector base write/read
    vb = 4'hA;
    wr(10'h002, 16'hAFFF);
    check_status("R7 vector base", vb);

    // R12: unmapped offsets
    wr(10'h040, 16'hFFFF);
    rd(10'h040, d); check("R12 unmapped", d, 16'h0000);
    wr(ctrl_addr(NCTRL+1), 16'hFFFF);
    rd(ctrl_addr(NCTRL+1), d); check("R12 past last", d, 16'h0000);
    check_status("R12 no side effect", vb);

    // R9: upper raw word, only source 17 can show
    cfg_src(17, 0, 0, 2'b11, 3'd1);
    @(negedge clk) src_i[31:17] = '1;
    idle(4); m_pend[17] = 1;
    rd(10'h006, d); check("R9 raw hi", d, 16'h0002);

    // random phases
    for (int ph = 0; ph < 60; ph++) begin
      for (int n = 1; n <= NCTRL; n++)
        cfg_src(n, 1'($urandom), 1'b0, 2'($urandom), 3'($urandom));
      vb = 4'($urandom);
      wr(10'h002, {vb, 12'($urandom)});
      idle(4);
      old_in = src_i;
      @(negedge clk) src_i = NSRC'($urandom);
      idle(6);
      for (int n = 1; n <= NCTRL; n++) begin
        if (m_mode[n][0]) m_pend[n] = (src_i[n] == m_mode[n][1]);
        else              m_pend[n] = (old_in[n] != src_i[n]) && (src_i[n] == m_mode[n][1]);
      end
      check_status("R5 random", vb);
      rd(10'h004, d); check("R9 random lo", d, exp_raw(0));
      rd(10'h006, d); check("R9 random hi", d, exp_raw(16));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule